// File: doc/BRIEF.md
# Multi-mode DMA channel engine

This block is one DMA channel that moves data between memory and peripherals with no processor in the loop. A start strobe launches a transfer. At that strobe the engine captures a source address, a destination address, an element count, a transfer mode, an element size, a burst flag and a byte-swap flag. Each element is read over a single-beat bus master port into an internal holding register and then written back out. Both phases can be stalled by the bus ready signal.

There are three transfer modes. Memory copy advances both addresses. Memory-to-peripheral keeps the destination address fixed. Peripheral-to-memory keeps the source address fixed. In the two peripheral modes, every element waits for a request from the peripheral. The peripheral can mark a request as the final one, which ends the transfer early. Memory copy can also run in bursts: groups of four words are read back to back and then written back to back. The engine reports the end of a transfer with a one-cycle done pulse.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `bus_req` and `per_ack` are all low.
- R2: Mode code 0 (memory copy) moves `cfg_len` elements. Source and destination addresses both advance by the element size (1, 2 or 4 bytes) after each element.
- R3: Mode code 1 (memory to peripheral) advances the source address while every write goes to the fixed destination address. Each element starts only after a peripheral request. Each completed element is acknowledged by a one-cycle `per_ack` pulse.
- R4: Mode code 2 (peripheral to memory) reads every element from the fixed source address and advances the destination address. Elements are request-paced and acknowledged as in R3.
- R5: Size codes are 0 = byte, 1 = half-word, 2 = word, and `bus_size` carries the code. A read element is taken from the byte lanes starting at lane `addr[1:0]` of `bus_rdata`. A written element is placed on the lanes starting at lane `addr[1:0]` of `bus_wdata`, and all other lanes are zero.
- R6: With `cfg_swap` set, the byte order inside each element is reversed: the two bytes of a half-word, the four bytes of a word. Bytes are unchanged.
- R7: With `cfg_burst` set in memory-copy mode, the engine uses word size regardless of `cfg_size`. It issues four word reads and then four word writes per group, with `cfg_len` counted in words as a multiple of four. In the peripheral modes `cfg_burst` has no effect.
- R8: A last-single request (`per_last`) in a peripheral mode moves that one element and then ends the transfer with done, even if programmed elements remain.
- R9: `done` is high for exactly one cycle after the final write completes. A start with `cfg_len` = 0 produces a done pulse and no bus traffic.
- R10: A start while the engine is busy is ignored. The running transfer keeps its captured configuration and no second transfer follows.
- R11: While `bus_req` is high and `bus_ready` is low, the request, direction, address and size are held steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, captured only when idle |
| cfg_mode | input | 2 | 0 memory copy, 1 memory to peripheral, 2 peripheral to memory |
| cfg_size | input | 2 | 0 byte, 1 half-word, 2 word |
| cfg_burst | input | 1 | Four-word grouping in memory-copy mode |
| cfg_swap | input | 1 | Reverse byte order within each element |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_len | input | LEN_W | Number of elements (words when bursting) |
| per_req | input | 1 | Peripheral single request |
| per_last | input | 1 | Peripheral last-single request |
| per_ack | output | 1 | One-cycle acknowledge after each paced element |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Byte address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Lane-aligned write data |
| bus_rdata | input | 32 | Read data |
| bus_ready | input | 1 | Access completes on a clock edge when high |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Terminal-count pulse |

## Verification
The bound checker watches, on every cycle, the rules that hold at any instant:
- the bus stays quiet while idle;
- a stalled access keeps its attributes;
- the fixed side of a peripheral transfer never moves;
- the captured configuration stays frozen during a transfer;
- bursts use word size;
- done never lasts two cycles.

What moves where, which lanes it occupies, what the swap does, the read/write grouping of a burst, early termination on a last-single request, and the rejection of a second start can only be shown by the bench. It sweeps the modes, sizes, offsets, lengths and stall patterns and compares every write against values derived from the address arithmetic.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int BUS_W       = 32;
    localparam int BURST_BEATS = 4;

    typedef enum logic [1:0] {
        XFER_M2M = 2'd0,
        XFER_M2P = 2'd1,
        XFER_P2M = 2'd2
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ELEM_BYTE = 2'd0,
        ELEM_HALF = 2'd1,
        ELEM_WORD = 2'd2
    } elem_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } eng_state_e;

    typedef struct packed {
        xfer_mode_e mode;
        elem_size_e size;
        logic       burst;
        logic       swap;
    } xfer_cfg_t;

    function automatic logic [2:0] elem_bytes(elem_size_e sz);
        case (sz)
            ELEM_BYTE: return 3'd1;
            ELEM_HALF: return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

    function automatic logic src_moves(xfer_mode_e m);
        return m != XFER_P2M;
    endfunction

    function automatic logic dst_moves(xfer_mode_e m);
        return m != XFER_M2P;
    endfunction

    function automatic logic is_paced(xfer_mode_e m);
        return m != XFER_M2M;
    endfunction

    // Right-justify the element that sits at byte lane lo.
    function automatic logic [BUS_W-1:0] lane_extract(logic [BUS_W-1:0] word,
                                                      logic [1:0] lo,
                                                      elem_size_e sz);
        logic [BUS_W-1:0] sh;
        sh = word >> {lo, 3'b000};
        case (sz)
            ELEM_BYTE: return {24'b0, sh[7:0]};
            ELEM_HALF: return {16'b0, sh[15:0]};
            default:   return sh;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] swap_elem(logic [BUS_W-1:0] e,
                                                   elem_size_e sz);
        case (sz)
            ELEM_BYTE: return e;
            ELEM_HALF: return {16'b0, e[7:0], e[15:8]};
            default:   return {e[7:0], e[15:8], e[23:16], e[31:24]};
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] lane_place(logic [BUS_W-1:0] e,
                                                    logic [1:0] lo);
        return e << {lo, 3'b000};
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [1:0][ADDR_W-1:0] base,
    input  logic [1:0]             step_en,
    input  logic [2:0]             step_amt,
    output logic [1:0][ADDR_W-1:0] ptr
);
    // pointer 0 = source, pointer 1 = destination
    for (genvar p = 0; p < 2; p++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr[p] <= '0;
            end else if (load) begin
                ptr[p] <= base[p];
            end else if (step_en[p]) begin
                ptr[p] <= ptr[p] + ADDR_W'(step_amt);
            end
        end
    end
endmodule

// File: rtl/dma_hold_buf.sv
module dma_hold_buf #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] ent [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                ent[i] <= wr_data;
            end
        end
    end

    assign rd_data = ent[rd_idx];
endmodule

// File: rtl/dma_lane_unit.sv
module dma_lane_unit
    import dma_eng_pkg::*;
(
    input  logic [BUS_W-1:0] rd_word,
    input  logic [1:0]       src_lo,
    input  logic [1:0]       dst_lo,
    input  elem_size_e       size,
    input  logic             swap,
    input  logic [BUS_W-1:0] held,
    output logic [BUS_W-1:0] elem_in,
    output logic [BUS_W-1:0] wr_word
);
    logic [BUS_W-1:0] raw;

    always_comb begin
        raw     = lane_extract(rd_word, src_lo, size);
        elem_in = swap ? swap_elem(raw, size) : raw;
        wr_word = lane_place(held, dst_lo);
    end
endmodule

// File: rtl/dma_ctrl_fsm.sv
module dma_ctrl_fsm
    import dma_eng_pkg::*;
#(
    parameter int LEN_W = 16,
    localparam int BEAT_W = $clog2(BURST_BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_burst,
    input  logic              cfg_swap,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              per_req,
    input  logic              per_last,
    input  logic              bus_ready,
    output eng_state_e        st,
    output xfer_cfg_t         cfg_q,
    output logic [BEAT_W-1:0] beat,
    output logic              load,
    output logic              per_ack
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);

    xfer_cfg_t        norm;
    logic [LEN_W-1:0] remain;
    logic             last_q;

    always_comb begin
        norm.mode  = (cfg_mode == 2'd3) ? XFER_M2M : xfer_mode_e'(cfg_mode);
        norm.swap  = cfg_swap;
        norm.burst = cfg_burst && (norm.mode == XFER_M2M);
        norm.size  = (norm.burst || cfg_size == 2'd3) ? ELEM_WORD
                                                      : elem_size_e'(cfg_size);
    end

    assign load = (st == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cfg_q   <= '0;
            remain  <= '0;
            beat    <= '0;
            last_q  <= 1'b0;
            per_ack <= 1'b0;
        end else begin
            per_ack <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q  <= norm;
                        remain <= cfg_len;
                        beat   <= '0;
                        last_q <= 1'b0;
                        if (cfg_len == '0)
                            st <= ST_DONE;
                        else if (is_paced(norm.mode))
                            st <= ST_WAIT_REQ;
                        else
                            st <= ST_READ;
                    end
                end
                ST_WAIT_REQ: begin
                    if (!per_ack && (per_req || per_last)) begin
                        last_q <= per_last;
                        st     <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (bus_ready) begin
                        if (cfg_q.burst && beat != LAST_BEAT) begin
                            beat <= beat + 1'b1;
                        end else begin
                            beat <= '0;
                            st   <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (bus_ready) begin
                        remain <= remain - 1'b1;
                        if (is_paced(cfg_q.mode))
                            per_ack <= 1'b1;
                        if (remain == LEN_W'(1) || last_q) begin
                            beat <= '0;
                            st   <= ST_DONE;
                        end else if (cfg_q.burst) begin
                            if (beat == LAST_BEAT) begin
                                beat <= '0;
                                st   <= ST_READ;
                            end else begin
                                beat <= beat + 1'b1;
                            end
                        end else if (is_paced(cfg_q.mode)) begin
                            st <= ST_WAIT_REQ;
                        end else begin
                            st <= ST_READ;
                        end
                    end
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_size,
    input  logic              cfg_burst,
    input  logic              cfg_swap,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_dst,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              per_req,
    input  logic              per_last,
    output logic              per_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_ready,
    output logic              busy,
    output logic              done
);
    localparam int BEAT_W = $clog2(BURST_BEATS);

    eng_state_e             st;
    xfer_cfg_t              cfg_q;
    logic [BEAT_W-1:0]      beat;
    logic                   load;
    logic [1:0][ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0]      src_q;
    logic [ADDR_W-1:0]      dst_q;
    logic                   rd_fire;
    logic                   wr_fire;
    logic [BUS_W-1:0]       elem_in;
    logic [BUS_W-1:0]       held;

    dma_ctrl_fsm #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_mode  (cfg_mode),
        .cfg_size  (cfg_size),
        .cfg_burst (cfg_burst),
        .cfg_swap  (cfg_swap),
        .cfg_len   (cfg_len),
        .per_req   (per_req),
        .per_last  (per_last),
        .bus_ready (bus_ready),
        .st        (st),
        .cfg_q     (cfg_q),
        .beat      (beat),
        .load      (load),
        .per_ack   (per_ack)
    );

    assign rd_fire = (st == ST_READ)  && bus_ready;
    assign wr_fire = (st == ST_WRITE) && bus_ready;

    dma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .base     ({cfg_dst, cfg_src}),
        .step_en  ({wr_fire && dst_moves(cfg_q.mode),
                    rd_fire && src_moves(cfg_q.mode)}),
        .step_amt (elem_bytes(cfg_q.size)),
        .ptr      (ptr)
    );

    assign src_q = ptr[0];
    assign dst_q = ptr[1];

    dma_hold_buf #(.DEPTH(BURST_BEATS), .W(BUS_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rd_fire),
        .wr_idx  (beat),
        .wr_data (elem_in),
        .rd_idx  (beat),
        .rd_data (held)
    );

    dma_lane_unit u_lane (
        .rd_word (bus_rdata),
        .src_lo  (src_q[1:0]),
        .dst_lo  (dst_q[1:0]),
        .size    (cfg_q.size),
        .swap    (cfg_q.swap),
        .held    (held),
        .elem_in (elem_in),
        .wr_word (bus_wdata)
    );

    always_comb begin
        bus_req  = (st == ST_READ) || (st == ST_WRITE);
        bus_we   = (st == ST_WRITE);
        bus_addr = bus_we ? dst_q : src_q;
        bus_size = cfg_q.size;
        busy     = (st != ST_IDLE);
        done     = (st == ST_DONE);
    end
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk
    import dma_eng_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              bus_ready,
    input logic              per_ack,
    input xfer_cfg_t         cfg_q,
    input logic [ADDR_W-1:0] src_q,
    input logic [ADDR_W-1:0] dst_q
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_req && !per_ack && !done));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_dst_fixed: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && cfg_q.mode == XFER_M2P) |-> $stable(dst_q));

    a_r4_src_fixed: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && cfg_q.mode == XFER_P2M) |-> $stable(src_q));

    a_r11_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) &&
                                     $stable(bus_addr) && $stable(bus_size)));

    a_r7_burst_word: assert property (@(posedge clk) disable iff (rst)
        (bus_req && cfg_q.burst) |-> (bus_size == 2'd2 && cfg_q.mode == XFER_M2M));

    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));

    a_r5_size_legal: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> bus_size != 2'd3);

    a_r3_ack_paced: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> cfg_q.mode != XFER_M2M);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_ready (bus_ready),
    .per_ack   (per_ack),
    .cfg_q     (cfg_q),
    .src_q     (src_q),
    .dst_q     (dst_q)
);

// File: tb/test_dma_chan_engine.sv
`timescale 1ns/1ps
module test_dma_chan_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = '0, cfg_size = '0;
    logic        cfg_burst = 1'b0, cfg_swap = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [15:0] cfg_len = '0;
    logic        per_req = 1'b0, per_last = 1'b0;
    logic        per_ack, bus_req, bus_we, bus_ready = 1'b1, busy, done;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;

    int total = 0, bad = 0;
    int nw, nr, ntx, done_cnt, ack_cnt, issued, per_total, last_at, rdy_cnt = 0;
    logic per_en = 1'b0, stall_en = 1'b0, finished = 1'b0;
    logic [31:0] wl_addr [64];
    logic [31:0] wl_data [64];
    logic [1:0]  wl_size [64];
    logic [31:0] rl_addr [64];
    logic        seq_we  [64];

    always #10 clk = ~clk;

    dma_chan_engine i_dma_chan_engine (
        .clk(clk), .rst(rst), .start(start), .cfg_mode(cfg_mode),
        .cfg_size(cfg_size), .cfg_burst(cfg_burst), .cfg_swap(cfg_swap),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
        .per_req(per_req), .per_last(per_last), .per_ack(per_ack),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .busy(busy), .done(done)
    );

    function automatic logic [7:0] membyte(logic [31:0] a);
        return 8'(a * 7 + 3);
    endfunction

    function automatic logic [31:0] memword(logic [31:0] a);
        logic [31:0] b = {a[31:2], 2'b00};
        return {membyte(b + 3), membyte(b + 2), membyte(b + 1), membyte(b)};
    endfunction

    always_comb bus_rdata = memword(bus_addr);

    // bus slave, monitor and peripheral model, all acting off the edges
    always begin
        @(negedge clk);
        bus_ready = stall_en ? (rdy_cnt % 3 != 1) : 1'b1;
        rdy_cnt++;
        #5;
        if (bus_req && bus_ready && ntx < 64) begin
            seq_we[ntx] = bus_we;
            ntx++;
            if (bus_we) begin
                wl_addr[nw] = bus_addr; wl_data[nw] = bus_wdata; wl_size[nw] = bus_size;
                nw++;
            end else begin
                rl_addr[nr] = bus_addr;
                nr++;
            end
        end
        if (done) done_cnt++;
        if (per_ack) ack_cnt++;
        if (per_req || per_last) begin
            if (per_ack) begin per_req = 1'b0; per_last = 1'b0; end
        end else if (per_en && busy && !per_ack && issued < per_total) begin
            if (issued == last_at) per_last = 1'b1; else per_req = 1'b1;
            issued++;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] mode, input logic [1:0] size,
                       input logic burst, input logic swap,
                       input logic [31:0] src, input logic [31:0] dst,
                       input logic [15:0] len, input int lastx, input logic poke);
        nw = 0; nr = 0; ntx = 0; done_cnt = 0; ack_cnt = 0; issued = 0;
        last_at = lastx;
        per_total = (lastx >= 0) ? lastx + 1 : int'(len);
        per_en = (mode != 2'd0);
        @(negedge clk);
        cfg_mode = mode; cfg_size = size; cfg_burst = burst; cfg_swap = swap;
        cfg_src = src; cfg_dst = dst; cfg_len = len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            cfg_mode = 2'd1; cfg_src = 32'h300; cfg_len = 16'd9; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 3000 && done_cnt == 0; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        per_en = 1'b0;
    endtask

    // expected writes of a single-element-style transfer
    task automatic verify(string tag, input logic [1:0] mode, input logic [1:0] size,
                          input logic swap, input logic [31:0] src,
                          input logic [31:0] dst, input int nexp);
        int n = 1 << size;
        chk(tag, "write count", 32'(nw), 32'(nexp));
        chk(tag, "read count", 32'(nr), 32'(nexp));
        chk("R9", "done pulses", 32'(done_cnt), 32'd1);
        chk(tag, "ack count", 32'(ack_cnt), (mode != 2'd0) ? 32'(nexp) : 32'd0);
        for (int k = 0; k < nexp && k < nw && k < nr; k++) begin
            logic [31:0] s = src + ((mode != 2'd2) ? 32'(k * n) : 32'd0);
            logic [31:0] d = dst + ((mode != 2'd1) ? 32'(k * n) : 32'd0);
            logic [31:0] e = '0;
            for (int j = 0; j < n; j++)
                e[8*j +: 8] = swap ? membyte(s + 32'(n - 1 - j)) : membyte(s + 32'(j));
            chk(tag, "read address", rl_addr[k], s);
            chk(tag, "write address", wl_addr[k], d);
            chk(swap ? "R6" : "R5", "write data", wl_data[k], e << (8 * d[1:0]));
            chk("R5", "bus size", 32'(wl_size[k]), 32'(size));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "idle outputs after reset",
            {28'b0, busy, done, bus_req, per_ack}, 32'd0);

        // sweep of modes, sizes, swap, offsets, lengths, stall patterns
        for (int st = 0; st < 2; st++)
            for (int m = 0; m < 3; m++)
                for (int sz = 0; sz < 3; sz++)
                    for (int b = 0; b < 2; b++)
                        for (int sw = 0; sw < 2; sw++)
                            for (int off = 0; off < 2; off++)
                                for (int ln = 1; ln <= 3; ln++) begin
                                    logic [31:0] sa = 32'h40 + 32'((off + ln) * (1 << sz));
                                    logic [31:0] da = 32'h80 + 32'((1 - off) * (1 << sz));
                                    string tg = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
                                    if (m == 0 && b == 1) continue;
                                    if (b == 1) tg = "R7";
                                    stall_en = (st == 1);
                                    run(2'(m), 2'(sz), b[0], sw[0], sa, da, 16'(ln), -1, 1'b0);
                                    verify(tg, 2'(m), 2'(sz), sw[0], sa, da, ln);
                                end

        // R7: burst memory copy of eight words, byte size requested
        stall_en = 1'b1;
        run(2'd0, 2'd0, 1'b1, 1'b0, 32'h100, 32'h200, 16'd8, -1, 1'b0);
        chk("R7", "burst transactions", 32'(ntx), 32'd16);
        for (int i = 0; i < 16 && i < ntx; i++)
            chk("R7", "burst read/write grouping", 32'(seq_we[i]), 32'((i / 4) % 2));
        for (int k = 0; k < 8 && k < nw && k < nr; k++) begin
            chk("R7", "burst read address", rl_addr[k], 32'h100 + 32'(4 * k));
            chk("R7", "burst write address", wl_addr[k], 32'h200 + 32'(4 * k));
            chk("R7", "burst write data", wl_data[k], memword(32'h100 + 32'(4 * k)));
            chk("R7", "burst size word", 32'(wl_size[k]), 32'd2);
        end
        chk("R9", "burst done pulses", 32'(done_cnt), 32'd1);

        // R8: last-single on the second element of five
        run(2'd1, 2'd2, 1'b0, 1'b0, 32'h20, 32'h400, 16'd5, 1, 1'b0);
        verify("R8", 2'd1, 2'd2, 1'b0, 32'h20, 32'h400, 2);
        run(2'd2, 2'd0, 1'b0, 1'b1, 32'h23, 32'h90, 16'd4, 0, 1'b0);
        verify("R8", 2'd2, 2'd0, 1'b1, 32'h23, 32'h90, 1);

        // R9: zero length
        run(2'd0, 2'd2, 1'b0, 1'b0, 32'h10, 32'h50, 16'd0, -1, 1'b0);
        chk("R9", "zero length bus traffic", 32'(ntx), 32'd0);
        chk("R9", "zero length done pulses", 32'(done_cnt), 32'd1);

        // R10: second start while busy is ignored
        run(2'd0, 2'd2, 1'b0, 1'b0, 32'h60, 32'hA0, 16'd3, -1, 1'b1);
        verify("R10", 2'd0, 2'd2, 1'b0, 32'h60, 32'hA0, 3);
        chk("R10", "idle after ignored start", 32'(busy), 32'd0);

        // R11: a long stalled copy still moves the right data
        run(2'd0, 2'd1, 1'b0, 1'b1, 32'h12, 32'hC2, 16'd6, -1, 1'b0);
        verify("R11", 2'd0, 2'd1, 1'b1, 32'h12, 32'hC2, 6);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule